// File: doc/BRIEF.md
# Read-Strobe Timing Count Calculator

This block turns a NAND interface timing mode (0 to 5) and the controller clock period in nanoseconds into the cycle counts a flash interface sequencer needs. These counts cover the read-strobe low and high widths, the data access delay, the address-to-data gap, the three strobe turnaround gaps and the chip-select setup time. The nanosecond limits for each mode are held inside the block. A `start_i` pulse captures the mode and period. The block then works out every count with one small step per clock and raises `done_o` once all counts can be used.

The counts come from more than a rounded-up division. The strobe high width gets an extra cycle when its margin is thin. The low width is widened until three things hold: the full read cycle meets its minimum, the two widths together reach a minimum cycle total, and the window in which read data is valid is at least 8 ns. The access count and chip-select setup count are also raised until their own margins are met. While the calculation runs, the output counts are intermediate values. They are meaningful only while `done_o` is high.

Top module: `onfi_tcalc`

## Requirements
- R1: A clock edge with `start_i` high captures `mode_i` and `period_ns_i` and starts a new calculation (also while one is in progress); `done_o` is low in the cycle after that edge and rises later with all counts final.
- R2: While `done_o` is high and `start_i` stays low, `done_o` and every count output hold their values, whatever `mode_i` and `period_ns_i` do.
- R3: A captured mode above 5 is used as mode 5, and a captured period of 0 is used as 1 ns.
- R4: The strobe high count H is the smallest count with H×P ≥ tREH (P is the period), plus one extra cycle when H×P < tREH + 2.
- R5: The strobe low count L starts as the smallest count with L×P ≥ tRP and is then raised by the fewest cycles that make (L+H)×P ≥ tRC.
- R6: If L+H is below MIN_RE_CYC (default 4), L is raised until L+H equals MIN_RE_CYC.
- R7: L is then raised one cycle at a time until min(L×P + tRHOH, (L+H)×P + tRLOH) − tREA ≥ 8.
- R8: The access count is the smallest A with A×P ≥ tREA and A×P − tREA ≥ 3.
- R9: The address-to-data, read-to-write, read-to-read and write-to-read counts are the smallest counts whose product with P reaches tADL, tRHW, tRHZ and tWHR respectively.
- R10: The chip-select setup count is the smallest C with C×P ≥ tCS − tRP and C×P + tREA ≥ tCEA.
- R11: Per-mode limits in ns, listed as (tRP, tREH, tRC, tREA, tRHOH, tRLOH, tCEA, tCS, tADL, tRHW, tRHZ, tWHR). Mode 0: (50,30,100,40,0,0,100,70,200,200,200,120). Mode 1: (25,15,50,30,15,0,45,35,100,100,100,80). Mode 2: (17,15,35,25,15,0,30,25,100,100,100,80). Mode 3: (15,10,30,20,15,0,25,25,100,100,100,60). Mode 4: (12,10,25,20,15,5,25,20,70,100,100,60). Mode 5: (10,7,20,16,15,5,25,15,70,100,100,60).
- R12: After synchronous reset, `done_o` is low and every count output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Capture mode and period and begin a calculation |
| mode_i | input | 3 | Timing mode, 0 to 5 (higher values act as 5) |
| period_ns_i | input | CLK_W | Controller clock period in ns |
| done_o | output | 1 | All counts are final |
| re_low_o | output | CNT_W | Read-strobe low width in cycles |
| re_high_o | output | CNT_W | Read-strobe high width in cycles |
| access_o | output | CNT_W | Read access delay in cycles |
| addr_data_o | output | CNT_W | Address-to-data gap in cycles |
| re_we_o | output | CNT_W | Read-strobe to write-strobe gap in cycles |
| re_re_o | output | CNT_W | Read-strobe to read-strobe gap in cycles |
| we_re_o | output | CNT_W | Write-strobe to read-strobe gap in cycles |
| cs_setup_o | output | CNT_W | Chip-select setup in cycles |

## Verification
Each input pair is chosen so that a different adjustment decides the result. A 10 ns period in mode 0 brings in the high-width bump, the read-cycle raise, the access margin and a chip-select loop that takes several steps. A 20 ns period in mode 5 is settled only by the minimum cycle total. A 1 ns period in mode 3 makes the access margin loop run three times and shows whether the rounding is exact. A 7 ns period in mode 1 leaves remainders that are not whole, which separates a wrong rounding direction from a correct one. An out-of-range mode and a zero period are compared with their in-range counterparts. Inputs are also changed while `done_o` is high, to show that the results hold.

// File: rtl/onfi_tcalc_pkg.sv
package onfi_tcalc_pkg;

    localparam int TNS_W    = 8;
    localparam int MODE_W   = 3;
    localparam int MAX_MODE = 5;

    localparam int G_ACC  = 0;
    localparam int G_ADL  = 1;
    localparam int G_RHW  = 2;
    localparam int G_RHZ  = 3;
    localparam int G_WHR  = 4;
    localparam int G_CS   = 5;
    localparam int N_GROW = 6;

    typedef logic [TNS_W-1:0] tns_t;

    typedef struct packed {
        tns_t rea;
        tns_t rp;
        tns_t reh;
        tns_t rc;
        tns_t rhoh;
        tns_t rloh;
        tns_t cea;
        tns_t adl;
        tns_t rhw;
        tns_t rhz;
        tns_t whr;
        tns_t cs;
    } mode_times_t;

    typedef enum logic [2:0] {
        RE_IDLE,
        RE_BASE,
        RE_HOLD,
        RE_CYCLE,
        RE_MULT,
        RE_WINDOW,
        RE_FIN
    } re_phase_t;

    function automatic logic [MODE_W-1:0] clamp_mode(input logic [MODE_W-1:0] m);
        return (int'(m) > MAX_MODE) ? MODE_W'(MAX_MODE) : m;
    endfunction

    function automatic mode_times_t lookup_times(input logic [MODE_W-1:0] m);
        mode_times_t t;
        case (m)
            3'd0: t = '{rea:8'd40, rp:8'd50, reh:8'd30, rc:8'd100, rhoh:8'd0, rloh:8'd0,
                        cea:8'd100, adl:8'd200, rhw:8'd200, rhz:8'd200, whr:8'd120, cs:8'd70};
            3'd1: t = '{rea:8'd30, rp:8'd25, reh:8'd15, rc:8'd50, rhoh:8'd15, rloh:8'd0,
                        cea:8'd45, adl:8'd100, rhw:8'd100, rhz:8'd100, whr:8'd80, cs:8'd35};
            3'd2: t = '{rea:8'd25, rp:8'd17, reh:8'd15, rc:8'd35, rhoh:8'd15, rloh:8'd0,
                        cea:8'd30, adl:8'd100, rhw:8'd100, rhz:8'd100, whr:8'd80, cs:8'd25};
            3'd3: t = '{rea:8'd20, rp:8'd15, reh:8'd10, rc:8'd30, rhoh:8'd15, rloh:8'd0,
                        cea:8'd25, adl:8'd100, rhw:8'd100, rhz:8'd100, whr:8'd60, cs:8'd25};
            3'd4: t = '{rea:8'd20, rp:8'd12, reh:8'd10, rc:8'd25, rhoh:8'd15, rloh:8'd5,
                        cea:8'd25, adl:8'd70, rhw:8'd100, rhz:8'd100, whr:8'd60, cs:8'd20};
            default: t = '{rea:8'd16, rp:8'd10, reh:8'd7, rc:8'd20, rhoh:8'd15, rloh:8'd5,
                        cea:8'd25, adl:8'd70, rhw:8'd100, rhz:8'd100, whr:8'd60, cs:8'd15};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/onfi_tcalc_grow.sv
module onfi_tcalc_grow #(
    parameter int CLK_W = 8,
    parameter int CNT_W = 8,
    parameter int NS_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CLK_W-1:0] step,
    input  logic [NS_W-1:0]  tgt_a,
    input  logic [NS_W-1:0]  tgt_b,
    output logic [CNT_W-1:0] cnt_o,
    output logic             idle_o
);

    logic [NS_W-1:0]  prod_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             short_w;

    assign short_w = (prod_q < tgt_a) || (prod_q < tgt_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (load) begin
            prod_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (active_q) begin
            if (short_w) begin
                prod_q <= prod_q + NS_W'(step);
                cnt_q  <= cnt_q + CNT_W'(1);
            end else begin
                active_q <= 1'b0;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign idle_o = !active_q;

    // R8 R9 R10: when a count settles its product covers both limits
    p_grow_met_r9: assert property (@(posedge clk) disable iff (rst)
        ($fell(active_q) && !load) |-> (prod_q >= tgt_a) && (prod_q >= tgt_b));

    // R9: a settled count does not move until reloaded
    p_grow_still_r9: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/onfi_tcalc_re.sv
module onfi_tcalc_re
    import onfi_tcalc_pkg::*;
#(
    parameter int CLK_W          = 8,
    parameter int CNT_W          = 8,
    parameter int NS_W           = 16,
    parameter int MIN_RE_CYC     = 4,
    parameter int HOLD_MARGIN_NS = 2,
    parameter int WIN_MARGIN_NS  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CLK_W-1:0] step,
    input  tns_t             t_rp,
    input  tns_t             t_reh,
    input  tns_t             t_rc,
    input  tns_t             t_rea,
    input  tns_t             t_rhoh,
    input  tns_t             t_rloh,
    output logic [CNT_W-1:0] lo_cnt_o,
    output logic [CNT_W-1:0] hi_cnt_o,
    output logic             fin_o
);

    localparam logic [NS_W-1:0]  HOLD_NS = NS_W'(HOLD_MARGIN_NS);
    localparam logic [NS_W-1:0]  WIN_NS  = NS_W'(WIN_MARGIN_NS);
    localparam logic [CNT_W:0]   MIN_CNT = (CNT_W+1)'(MIN_RE_CYC);

    re_phase_t        phase_q, phase_d;
    logic [CNT_W-1:0] lo_q, hi_q;
    logic [NS_W-1:0]  lo_ns_q, hi_ns_q;
    logic             bump_lo, bump_hi;

    logic [NS_W-1:0]  step_ns, sum_ns, inval_a, inval_b, inval_ns;
    logic [CNT_W:0]   sum_cnt;
    logic             window_ok;

    assign step_ns   = NS_W'(step);
    assign sum_ns    = lo_ns_q + hi_ns_q;
    assign sum_cnt   = {1'b0, lo_q} + {1'b0, hi_q};
    assign inval_a   = lo_ns_q + NS_W'(t_rhoh);
    assign inval_b   = sum_ns + NS_W'(t_rloh);
    assign inval_ns  = (inval_a < inval_b) ? inval_a : inval_b;
    assign window_ok = inval_ns >= (NS_W'(t_rea) + WIN_NS);

    always_comb begin
        phase_d = phase_q;
        bump_lo = 1'b0;
        bump_hi = 1'b0;
        case (phase_q)
            RE_BASE: begin
                bump_lo = lo_ns_q < NS_W'(t_rp);
                bump_hi = hi_ns_q < NS_W'(t_reh);
                if (!bump_lo && !bump_hi) phase_d = RE_HOLD;
            end
            RE_HOLD: begin
                bump_hi = hi_ns_q < (NS_W'(t_reh) + HOLD_NS);
                phase_d = RE_CYCLE;
            end
            RE_CYCLE: begin
                if (sum_ns < NS_W'(t_rc)) bump_lo = 1'b1;
                else                      phase_d = RE_MULT;
            end
            RE_MULT: begin
                if (sum_cnt < MIN_CNT) bump_lo = 1'b1;
                else                   phase_d = RE_WINDOW;
            end
            RE_WINDOW: begin
                if (!window_ok) bump_lo = 1'b1;
                else            phase_d = RE_FIN;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= RE_IDLE;
            lo_q    <= '0;
            hi_q    <= '0;
            lo_ns_q <= '0;
            hi_ns_q <= '0;
        end else if (load) begin
            phase_q <= RE_BASE;
            lo_q    <= '0;
            hi_q    <= '0;
            lo_ns_q <= '0;
            hi_ns_q <= '0;
        end else begin
            phase_q <= phase_d;
            if (bump_lo) begin
                lo_q    <= lo_q + CNT_W'(1);
                lo_ns_q <= lo_ns_q + step_ns;
            end
            if (bump_hi) begin
                hi_q    <= hi_q + CNT_W'(1);
                hi_ns_q <= hi_ns_q + step_ns;
            end
        end
    end

    assign lo_cnt_o = lo_q;
    assign hi_cnt_o = hi_q;
    assign fin_o    = (phase_q == RE_FIN);

    // R4 R5: final widths cover the strobe low and high minimums
    p_base_cover_r4: assert property (@(posedge clk) disable iff (rst)
        (fin_o && !load) |-> (lo_ns_q >= NS_W'(t_rp)) && (hi_ns_q >= NS_W'(t_reh)));

    // R5: full read cycle is met
    p_cycle_met_r5: assert property (@(posedge clk) disable iff (rst)
        (fin_o && !load) |-> (sum_ns >= NS_W'(t_rc)));

    // R6: cycle total reaches the minimum
    p_min_total_r6: assert property (@(posedge clk) disable iff (rst)
        (fin_o && !load) |-> (sum_cnt >= MIN_CNT));

    // R7: data window margin holds at the end
    p_window_r7: assert property (@(posedge clk) disable iff (rst)
        (fin_o && !load) |-> window_ok);

    // R4: the high count never moves after the hold step
    p_hi_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && (phase_q == RE_CYCLE || phase_q == RE_MULT || phase_q == RE_WINDOW))
        |=> $stable(hi_q));

endmodule

// File: rtl/onfi_tcalc.sv
module onfi_tcalc
    import onfi_tcalc_pkg::*;
#(
    parameter int CLK_W         = 8,
    parameter int CNT_W         = 8,
    parameter int MIN_RE_CYC    = 4,
    parameter int ACC_MARGIN_NS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [CLK_W-1:0]  period_ns_i,
    output logic              done_o,
    output logic [CNT_W-1:0]  re_low_o,
    output logic [CNT_W-1:0]  re_high_o,
    output logic [CNT_W-1:0]  access_o,
    output logic [CNT_W-1:0]  addr_data_o,
    output logic [CNT_W-1:0]  re_we_o,
    output logic [CNT_W-1:0]  re_re_o,
    output logic [CNT_W-1:0]  we_re_o,
    output logic [CNT_W-1:0]  cs_setup_o
);

    localparam int NS_W = CLK_W + CNT_W;

    logic [MODE_W-1:0] mode_q;
    logic [CLK_W-1:0]  period_q;
    logic              kick_q, running_q, done_q;
    mode_times_t       tm;

    logic [NS_W-1:0]   tgt_a [N_GROW];
    logic [NS_W-1:0]   tgt_b [N_GROW];
    logic [CNT_W-1:0]  grow_cnt [N_GROW];
    logic [N_GROW-1:0] grow_idle;
    logic              re_fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            period_q  <= '0;
            kick_q    <= 1'b0;
            running_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            kick_q <= start_i;
            if (start_i) begin
                mode_q    <= clamp_mode(mode_i);
                period_q  <= (period_ns_i == '0) ? CLK_W'(1) : period_ns_i;
                running_q <= 1'b1;
                done_q    <= 1'b0;
            end else if (running_q && !kick_q && (&grow_idle) && re_fin) begin
                running_q <= 1'b0;
                done_q    <= 1'b1;
            end
        end
    end

    assign tm = lookup_times(mode_q);

    always_comb begin
        for (int i = 0; i < N_GROW; i++) tgt_b[i] = '0;
        tgt_a[G_ACC] = NS_W'(tm.rea);
        tgt_b[G_ACC] = NS_W'(tm.rea) + NS_W'(ACC_MARGIN_NS);
        tgt_a[G_ADL] = NS_W'(tm.adl);
        tgt_a[G_RHW] = NS_W'(tm.rhw);
        tgt_a[G_RHZ] = NS_W'(tm.rhz);
        tgt_a[G_WHR] = NS_W'(tm.whr);
        tgt_a[G_CS]  = (tm.cs > tm.rp)   ? NS_W'(tm.cs - tm.rp)    : '0;
        tgt_b[G_CS]  = (tm.cea > tm.rea) ? NS_W'(tm.cea - tm.rea) : '0;
    end

    for (genvar g = 0; g < N_GROW; g++) begin : g_grow
        onfi_tcalc_grow #(
            .CLK_W (CLK_W),
            .CNT_W (CNT_W),
            .NS_W  (NS_W)
        ) u_grow (
            .clk    (clk),
            .rst    (rst),
            .load   (kick_q),
            .step   (period_q),
            .tgt_a  (tgt_a[g]),
            .tgt_b  (tgt_b[g]),
            .cnt_o  (grow_cnt[g]),
            .idle_o (grow_idle[g])
        );
    end

    onfi_tcalc_re #(
        .CLK_W      (CLK_W),
        .CNT_W      (CNT_W),
        .NS_W       (NS_W),
        .MIN_RE_CYC (MIN_RE_CYC)
    ) u_re (
        .clk      (clk),
        .rst      (rst),
        .load     (kick_q),
        .step     (period_q),
        .t_rp     (tm.rp),
        .t_reh    (tm.reh),
        .t_rc     (tm.rc),
        .t_rea    (tm.rea),
        .t_rhoh   (tm.rhoh),
        .t_rloh   (tm.rloh),
        .lo_cnt_o (re_low_o),
        .hi_cnt_o (re_high_o),
        .fin_o    (re_fin)
    );

    assign done_o      = done_q;
    assign access_o    = grow_cnt[G_ACC];
    assign addr_data_o = grow_cnt[G_ADL];
    assign re_we_o     = grow_cnt[G_RHW];
    assign re_re_o     = grow_cnt[G_RHZ];
    assign we_re_o     = grow_cnt[G_WHR];
    assign cs_setup_o  = grow_cnt[G_CS];

    // R1: a start always withdraws the previous result
    p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !done_o);

    // R2: a finished result is held until the next start
    p_done_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(re_low_o) && $stable(re_high_o)
            && $stable(access_o) && $stable(addr_data_o) && $stable(re_we_o)
            && $stable(re_re_o) && $stable(we_re_o) && $stable(cs_setup_o)));

    // R3: the captured operands stay in range
    p_operands_r3: assert property (@(posedge clk) disable iff (rst)
        running_q |-> ((int'(mode_q) <= MAX_MODE) && (period_q != '0)));

endmodule

// File: tb/onfi_tcalc_bench.sv
`timescale 1ns/1ps
module onfi_tcalc_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [2:0] mode_i = '0;
    logic [7:0] period_ns_i = '0;
    logic       done_o;
    logic [7:0] re_low_o, re_high_o, access_o, addr_data_o;
    logic [7:0] re_we_o, re_re_o, we_re_o, cs_setup_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    onfi_tcalc u_onfi_tcalc (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .period_ns_i (period_ns_i),
        .done_o      (done_o),
        .re_low_o    (re_low_o),
        .re_high_o   (re_high_o),
        .access_o    (access_o),
        .addr_data_o (addr_data_o),
        .re_we_o     (re_we_o),
        .re_re_o     (re_re_o),
        .we_re_o     (we_re_o),
        .cs_setup_o  (cs_setup_o)
    );

    // {mode, period, low, high, access, adl, rhw, rhz, whr, cs}
    localparam int NVEC = 4;
    localparam logic [74:0] VECS [NVEC] = '{
        {3'd0, 8'd10, 8'd6, 8'd4, 8'd5,  8'd20,  8'd20,  8'd20,  8'd12, 8'd6},
        {3'd5, 8'd5,  8'd2, 8'd2, 8'd4,  8'd14,  8'd20,  8'd20,  8'd12, 8'd2},
        {3'd1, 8'd7,  8'd5, 8'd3, 8'd5,  8'd15,  8'd15,  8'd15,  8'd12, 8'd3},
        {3'd3, 8'd1,  8'd19, 8'd11, 8'd23, 8'd100, 8'd100, 8'd100, 8'd60, 8'd10}
    };
    localparam logic [74:0] VEC_M5_P20 =
        {3'd5, 8'd20, 8'd3, 8'd1, 8'd1, 8'd4, 8'd5, 8'd5, 8'd3, 8'd1};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic run_calc(input logic [2:0] m, input logic [7:0] p);
        @(negedge clk);
        mode_i      = m;
        period_ns_i = p;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check_eq("R1", "done low after start", int'(done_o), 0);
        for (int i = 0; i < 2000; i++) begin
            if (done_o) break;
            @(negedge clk);
        end
        check_eq("R1", "done rises", int'(done_o), 1);
    endtask

    task automatic check_vec(input logic [74:0] v, input string tag);
        check_eq({tag, " R5 R11"}, "re_low",    int'(re_low_o),    int'(v[63:56]));
        check_eq({tag, " R4 R11"}, "re_high",   int'(re_high_o),   int'(v[55:48]));
        check_eq({tag, " R8 R11"}, "access",    int'(access_o),    int'(v[47:40]));
        check_eq({tag, " R9 R11"}, "addr_data", int'(addr_data_o), int'(v[39:32]));
        check_eq({tag, " R9 R11"}, "re_we",     int'(re_we_o),     int'(v[31:24]));
        check_eq({tag, " R9 R11"}, "re_re",     int'(re_re_o),     int'(v[23:16]));
        check_eq({tag, " R9 R11"}, "we_re",     int'(we_re_o),     int'(v[15:8]));
        check_eq({tag, " R10 R11"}, "cs_setup", int'(cs_setup_o),  int'(v[7:0]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] held [8];
        int win;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: reset state
        check_eq("R12", "done after reset", int'(done_o), 0);
        check_eq("R12", "counts after reset",
                 int'(re_low_o | re_high_o | access_o | addr_data_o |
                      re_we_o | re_re_o | we_re_o | cs_setup_o), 0);

        for (int k = 0; k < NVEC; k++) begin
            run_calc(VECS[k][74:72], VECS[k][71:64]);
            check_vec(VECS[k], $sformatf("vec%0d", k));
        end

        // R7: window margin for mode 1 at 7 ns from the outputs
        run_calc(3'd1, 8'd7);
        win = int'(re_low_o) * 7 + 15;
        if ((int'(re_low_o) + int'(re_high_o)) * 7 < win)
            win = (int'(re_low_o) + int'(re_high_o)) * 7;
        win = win - 30;
        check(win >= 8, "R7", "data window ns", win, 8);

        // R6: minimum cycle total decides mode 5 at 20 ns
        run_calc(3'd5, 8'd20);
        check_vec(VEC_M5_P20, "m5p20 R6");
        check_eq("R6", "low+high total", int'(re_low_o) + int'(re_high_o), 4);

        // R2: hold while inputs wander without start
        held = '{re_low_o, re_high_o, access_o, addr_data_o,
                 re_we_o, re_re_o, we_re_o, cs_setup_o};
        mode_i      = 3'd0;
        period_ns_i = 8'd1;
        repeat (6) @(negedge clk);
        check_eq("R2", "done held", int'(done_o), 1);
        check_eq("R2", "re_low held",   int'(re_low_o),   int'(held[0]));
        check_eq("R2", "re_high held",  int'(re_high_o),  int'(held[1]));
        check_eq("R2", "access held",   int'(access_o),   int'(held[2]));
        check_eq("R2", "cs_setup held", int'(cs_setup_o), int'(held[7]));
        check_eq("R2", "we_re held",    int'(we_re_o),    int'(held[6]));

        // R3: mode above 5 behaves as mode 5, zero period as 1 ns
        run_calc(3'd7, 8'd5);
        check_vec(VECS[1], "mode7 R3");
        run_calc(3'd3, 8'd0);
        check_vec(VECS[3], "period0 R3");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule